// File: doc/BRIEF.md
# Shared Multi-Bank Memory Port Fabric with Atomic Operations

This block lets several concurrently running kernels share one word-addressed memory that is split into independent banks. Each kernel computes its addresses at run time, so the target bank is taken from the address on every request rather than fixed at build time. The low word-address bits pick the bank and the remaining bits pick the row inside it. Consecutive words therefore land in different banks.

Each bank has its own round-robin arbiter. A request that meets no competitor for its bank is granted in the same cycle it is raised. Kernels that collide on one bank are served one per cycle in rotating order. Requests to different banks never delay each other.

Atomic add and compare-and-swap are executed next to the bank as a read phase followed by a write phase. The bank accepts no other request until the write phase is done, which makes these operations usable for synchronisation between kernels. Each bank drives a synchronous single-port RAM held inside the block. Read and atomic results return one cycle after the grant, on the issuing kernel's port only.

Top module: `mbi_mem_fabric`

## Requirements
- R1: A request's bank is address bits [1:0] and its row inside the bank is the remaining upper bits. Every one of the 256 word addresses is stored independently and reads back the value last written to it.
- R2: A request that is the only one aimed at its bank, while that bank is not locked, sees `k_ready` high in the same cycle it raises `k_req`.
- R3: Requests from different kernels to different banks in the same cycle are all granted in that cycle.
- R4: At most one kernel is granted per bank per cycle, and `k_ready` is never high for a kernel whose `k_req` is low.
- R5: Each bank arbitrates round-robin. The search for a winner starts at the kernel after the last one granted on that bank, wrapping from 3 to 0. After reset the search starts at kernel 0.
- R6: For a plain read (op 0 or 3 with `k_we` low) or an atomic op, `k_rvalid` pulses for one cycle, one cycle after the grant, on the issuing kernel only, with the data on that kernel's `k_rdata`. A plain write (op 0 or 3 with `k_we` high) produces no `k_rvalid`.
- R7: Op code 1 (atomic add) returns the old word and stores old + `k_wdata` modulo 2^32.
- R8: Op code 2 (compare-and-swap) returns the old word. It stores `k_wdata` only when the old word equals `k_cmp`; otherwise the word is left unchanged.
- R9: An atomic op holds its bank for the grant cycle and the following cycle. No request to that bank is granted in the following cycle, while other banks keep granting.
- R10: An atomic op code (1 or 2) takes precedence over `k_we`. Op code 3 behaves exactly like op code 0.
- R11: While reset is asserted and in the first cycle after it, `k_rvalid` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| k_req | input | NK | Request per kernel, held until ready |
| k_we | input | NK | Write enable per kernel for plain accesses |
| k_op | input | NK x 2 | Op per kernel: 0 plain, 1 add, 2 compare-and-swap, 3 plain |
| k_addr | input | NK x ADDR_W | Word address per kernel |
| k_wdata | input | NK x DATA_W | Write data, addend or swap value |
| k_cmp | input | NK x DATA_W | Compare operand for compare-and-swap |
| k_ready | output | NK | Request accepted this cycle |
| k_rvalid | output | NK | Return data valid pulse |
| k_rdata | output | NK x DATA_W | Return data |

## Verification
A corrupted round-robin pointer shows at `k_ready` as a wrong grant order the first time two kernels collide on that bank. A stuck or skipped atomic lock shows as a grant to a waiting kernel in the write-phase cycle. A stale pending operation shows as a wrong stored word on the next read of that address, two cycles later at the earliest. A bad return tag puts `k_rvalid` on the wrong kernel in the cycle right after the grant. Bank or row decode errors show as mismatched data when a full-address sweep is read back, which the bench compares word by word with its own model.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
    typedef enum logic [1:0] {
        OP_PLAIN = 2'd0,
        OP_ADD   = 2'd1,
        OP_CAS   = 2'd2,
        OP_ALT   = 2'd3
    } mbi_op_e;

    function automatic logic op_is_atomic(input logic [1:0] op);
        return (op == OP_ADD) || (op == OP_CAS);
    endfunction
endpackage

// File: rtl/mbi_sp_ram.sv
module mbi_sp_ram #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    // storage array, no reset
    always_ff @(posedge clk) begin
        if (en && we) mem_q[addr] <= wdata;
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)           rdata_q <= '0;
        else if (en && !we)   rdata_q <= mem_q[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/mbi_rr_arbiter.sv
module mbi_rr_arbiter #(
    parameter int N = 4,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    typedef struct packed {
        logic [PW-1:0] ptr;
    } arb_state_t;

    arb_state_t s_d, s_q;

    always_comb begin
        logic found;
        int   idx;
        s_d   = s_q;
        gnt   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(s_q.ptr) + i) % N;
            if (en && !found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
                s_d.ptr  = PW'((idx + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);
endmodule

// File: rtl/mbi_bank_ctrl.sv
module mbi_bank_ctrl
    import mbi_pkg::*;
#(
    parameter int NK     = 4,
    parameter int ROW_W  = 6,
    parameter int DATA_W = 32,
    localparam int KID_W = (NK > 1) ? $clog2(NK) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NK-1:0]                req_vec,
    input  logic [NK-1:0]                k_we,
    input  logic [NK-1:0][1:0]           k_op,
    input  logic [NK-1:0][ROW_W-1:0]     k_row,
    input  logic [NK-1:0][DATA_W-1:0]    k_wdata,
    input  logic [NK-1:0][DATA_W-1:0]    k_cmp,
    output logic [NK-1:0]                gnt,
    output logic                         ret_valid,
    output logic [KID_W-1:0]             ret_kid,
    output logic                         ram_en,
    output logic                         ram_we,
    output logic [ROW_W-1:0]             ram_addr,
    output logic [DATA_W-1:0]            ram_wdata,
    input  logic [DATA_W-1:0]            ram_rdata
);
    typedef struct packed {
        logic              pend_valid;
        logic [1:0]        pend_op;
        logic [ROW_W-1:0]  pend_row;
        logic [DATA_W-1:0] pend_wdata;
        logic [DATA_W-1:0] pend_cmp;
        logic              ret_valid;
        logic [KID_W-1:0]  ret_kid;
    } bank_state_t;

    bank_state_t s_d, s_q;
    logic             arb_en;
    logic [KID_W-1:0] win;
    logic             atomic_grant;

    // the bank is locked while an atomic write phase is pending
    assign arb_en = !s_q.pend_valid;

    mbi_rr_arbiter #(.N(NK)) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (arb_en),
        .req   (req_vec),
        .gnt   (gnt)
    );

    always_comb begin
        logic plain_wr;
        s_d            = s_q;
        s_d.pend_valid = 1'b0;
        s_d.ret_valid  = 1'b0;
        ram_en         = 1'b0;
        ram_we         = 1'b0;
        ram_addr       = '0;
        ram_wdata      = '0;
        atomic_grant   = 1'b0;
        win            = '0;
        plain_wr       = 1'b0;
        for (int i = 0; i < NK; i++) begin
            if (gnt[i]) win = KID_W'(i);
        end
        if (s_q.pend_valid) begin
            // write phase: old word is on the RAM read port now
            ram_en   = 1'b1;
            ram_addr = s_q.pend_row;
            if (s_q.pend_op == OP_ADD) begin
                ram_we    = 1'b1;
                ram_wdata = ram_rdata + s_q.pend_wdata;
            end else begin
                ram_we    = (ram_rdata == s_q.pend_cmp);
                ram_wdata = s_q.pend_wdata;
            end
        end else if (|gnt) begin
            atomic_grant  = op_is_atomic(k_op[win]);
            plain_wr      = !atomic_grant && k_we[win];
            ram_en        = 1'b1;
            ram_we        = plain_wr;
            ram_addr      = k_row[win];
            ram_wdata     = k_wdata[win];
            s_d.ret_valid = !plain_wr;
            s_d.ret_kid   = win;
            if (atomic_grant) begin
                s_d.pend_valid = 1'b1;
                s_d.pend_op    = k_op[win];
                s_d.pend_row   = k_row[win];
                s_d.pend_wdata = k_wdata[win];
                s_d.pend_cmp   = k_cmp[win];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ret_valid = s_q.ret_valid;
    assign ret_kid   = s_q.ret_kid;

    assert_lone_req_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && $countones(req_vec) == 1) |-> (gnt == req_vec));
    assert_atomic_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        atomic_grant |=> (gnt == '0));
    assert_return_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(|gnt));
    assert_lock_writes_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        atomic_grant |=> ram_en);
endmodule

// File: rtl/mbi_mem_fabric.sv
module mbi_mem_fabric #(
    parameter int NK     = 4,
    parameter int NB     = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NK-1:0]                 k_req,
    input  logic [NK-1:0]                 k_we,
    input  logic [NK-1:0][1:0]            k_op,
    input  logic [NK-1:0][ADDR_W-1:0]     k_addr,
    input  logic [NK-1:0][DATA_W-1:0]     k_wdata,
    input  logic [NK-1:0][DATA_W-1:0]     k_cmp,
    output logic [NK-1:0]                 k_ready,
    output logic [NK-1:0]                 k_rvalid,
    output logic [NK-1:0][DATA_W-1:0]     k_rdata
);
    localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1;
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int KID_W  = (NK > 1) ? $clog2(NK) : 1;

    logic [NK-1:0][ROW_W-1:0]   k_row;
    logic [NB-1:0][NK-1:0]      bank_req;
    logic [NB-1:0][NK-1:0]      bank_gnt;
    logic [NB-1:0]              ret_valid;
    logic [NB-1:0][KID_W-1:0]   ret_kid;
    logic [NB-1:0]              ram_en;
    logic [NB-1:0]              ram_we;
    logic [NB-1:0][ROW_W-1:0]   ram_addr;
    logic [NB-1:0][DATA_W-1:0]  ram_wdata;
    logic [NB-1:0][DATA_W-1:0]  ram_rdata;

    // runtime bank decode from the low word-address bits
    always_comb begin
        for (int k = 0; k < NK; k++) begin
            k_row[k] = k_addr[k][ADDR_W-1:BANK_W];
            for (int b = 0; b < NB; b++) begin
                bank_req[b][k] = k_req[k] && (k_addr[k][BANK_W-1:0] == BANK_W'(b));
            end
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        mbi_bank_ctrl #(
            .NK     (NK),
            .ROW_W  (ROW_W),
            .DATA_W (DATA_W)
        ) ctrl_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_vec   (bank_req[b]),
            .k_we      (k_we),
            .k_op      (k_op),
            .k_row     (k_row),
            .k_wdata   (k_wdata),
            .k_cmp     (k_cmp),
            .gnt       (bank_gnt[b]),
            .ret_valid (ret_valid[b]),
            .ret_kid   (ret_kid[b]),
            .ram_en    (ram_en[b]),
            .ram_we    (ram_we[b]),
            .ram_addr  (ram_addr[b]),
            .ram_wdata (ram_wdata[b]),
            .ram_rdata (ram_rdata[b])
        );

        mbi_sp_ram #(
            .DEPTH  (ROWS),
            .DATA_W (DATA_W)
        ) ram_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ram_en[b]),
            .we    (ram_we[b]),
            .addr  (ram_addr[b]),
            .wdata (ram_wdata[b]),
            .rdata (ram_rdata[b])
        );
    end

    // grant and return steering back to the kernels
    always_comb begin
        for (int k = 0; k < NK; k++) begin
            k_ready[k]  = 1'b0;
            k_rvalid[k] = 1'b0;
            k_rdata[k]  = '0;
            for (int b = 0; b < NB; b++) begin
                if (bank_gnt[b][k]) k_ready[k] = 1'b1;
                if (ret_valid[b] && ret_kid[b] == KID_W'(k)) begin
                    k_rvalid[k] = 1'b1;
                    k_rdata[k]  = ram_rdata[b];
                end
            end
        end
    end

    for (genvar k = 0; k < NK; k++) begin : g_kchk
        assert_rvalid_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
            k_rvalid[k] |-> $past(k_ready[k]));
        assert_ready_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
            k_ready[k] |-> k_req[k]);
    end
endmodule

// File: tb/mbi_mem_fabric_tb.sv
`timescale 1ns/1ps
module mbi_mem_fabric_tb_top;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        k_req, k_we;
    logic [3:0][1:0]   k_op;
    logic [3:0][7:0]   k_addr;
    logic [3:0][31:0]  k_wdata, k_cmp;
    logic [3:0]        k_ready, k_rvalid;
    logic [3:0][31:0]  k_rdata;

    logic [31:0] model [256];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mbi_mem_fabric dut_i (
        .clk(clk), .rst_n(rst_n), .k_req(k_req), .k_we(k_we), .k_op(k_op),
        .k_addr(k_addr), .k_wdata(k_wdata), .k_cmp(k_cmp),
        .k_ready(k_ready), .k_rvalid(k_rvalid), .k_rdata(k_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        k_req = '0; k_we = '0; k_op = '0; k_addr = '0; k_wdata = '0; k_cmp = '0;
    endtask

    // one kernel, one cycle; returns at the next falling edge with inputs idle
    task automatic issue(input int k, input logic we, input logic [1:0] op, input logic [7:0] a,
                         input logic [31:0] wd, input logic [31:0] cmp, input string tag);
        @(negedge clk);
        idle();
        k_req[k] = 1'b1; k_we[k] = we; k_op[k] = op; k_addr[k] = a;
        k_wdata[k] = wd; k_cmp[k] = cmp;
        #1;
        chk(k_ready == (4'b1 << k), tag, 32'(k_ready), 32'(4'b1 << k));
        @(negedge clk);
        idle();
    endtask

    task automatic do_read(input int k, input logic [7:0] a, input string tag);
        issue(k, 1'b0, 2'd0, a, 32'h0, 32'h0, tag);
        chk(k_rvalid == (4'b1 << k), tag, 32'(k_rvalid), 32'(4'b1 << k));
        chk(k_rdata[k] == model[a], tag, k_rdata[k], model[a]);
    endtask

    function automatic int pick(input logic [3:0] p, input int ptr);
        for (int i = 0; i < 4; i++) begin
            if (p[(ptr + i) % 4]) return (ptr + i) % 4;
        end
        return -1;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] old;
        int ptr0;
        idle();
        repeat (4) @(negedge clk);
        chk(k_rvalid == 4'b0, "R11 rvalid in reset", 32'(k_rvalid), 0);
        chk(k_ready == 4'b0, "R4 ready without req", 32'(k_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(k_rvalid == 4'b0, "R11 rvalid after reset", 32'(k_rvalid), 0);

        // R1 R2 R6: full write sweep from varying kernels, no return on writes
        for (int a = 0; a < 256; a++) begin
            model[a] = (32'(a) * 32'h0101_0101) ^ 32'h5A5A_0000;
            issue((a / 4) % 4, 1'b1, 2'd0, 8'(a), model[a], 32'h0, "R2 lone write ready");
            chk(k_rvalid == 4'b0, "R6 write has no return", 32'(k_rvalid), 0);
        end
        // R1 R6: full readback from other kernels
        for (int a = 0; a < 256; a++) begin
            do_read((a + 1) % 4, 8'(a), "R1 readback");
        end

        // R3: four kernels on four distinct banks at once
        for (int base = 0; base < 16; base++) begin
            @(negedge clk);
            idle();
            for (int k = 0; k < 4; k++) begin
                k_req[k] = 1'b1;
                k_addr[k] = 8'(base * 16 + k * 4 + ((k + base) % 4));
            end
            #1;
            chk(k_ready == 4'hF, "R3 parallel grant", 32'(k_ready), 32'hF);
            @(negedge clk);
            chk(k_rvalid == 4'hF, "R3 parallel return", 32'(k_rvalid), 32'hF);
            for (int k = 0; k < 4; k++) begin
                chk(k_rdata[k] == model[k_addr[k]], "R3 parallel data", k_rdata[k], model[k_addr[k]]);
            end
            idle();
        end

        // R5: every request pattern on bank 0, pointer primed to kernel 0
        do_read(3, 8'd0, "R5 prime");
        ptr0 = 0;
        for (int pat = 1; pat < 16; pat++) begin
            logic [3:0] pend;
            int last;
            pend = 4'(pat);
            last = -1;
            while (pend != 0 || last >= 0) begin
                @(negedge clk);
                idle();
                if (last >= 0) begin
                    chk(k_rvalid == (4'b1 << last), "R5 return owner", 32'(k_rvalid), 32'(4'b1 << last));
                    chk(k_rdata[last] == model[last * 4], "R5 return data", k_rdata[last], model[last * 4]);
                end
                last = -1;
                if (pend != 0) begin
                    int w;
                    w = pick(pend, ptr0);
                    for (int k = 0; k < 4; k++) begin
                        k_req[k] = pend[k];
                        k_addr[k] = 8'(k * 4);
                    end
                    #1;
                    chk(k_ready == (4'b1 << w), "R5 rotation order", 32'(k_ready), 32'(4'b1 << w));
                    pend[w] = 1'b0;
                    ptr0 = (w + 1) % 4;
                    last = w;
                end
            end
        end

        // R7: atomic add, plain and wrapping
        for (int i = 0; i < 6; i++) begin
            logic [7:0] a;
            logic [31:0] d;
            a = 8'(5 + i * 7);
            d = 32'h10 + 32'(i) * 32'h1111;
            old = model[a];
            issue(i % 4, 1'b0, 2'd1, a, d, 32'h0, "R7 add grant");
            chk(k_rvalid == (4'b1 << (i % 4)), "R7 add return", 32'(k_rvalid), 32'(4'b1 << (i % 4)));
            chk(k_rdata[i % 4] == old, "R7 add old value", k_rdata[i % 4], old);
            model[a] = old + d;
            do_read((i + 2) % 4, a, "R7 add stored");
        end
        model[9] = 32'hFFFF_FFFF;
        issue(2, 1'b1, 2'd0, 8'd9, model[9], 32'h0, "R7 wrap setup");
        issue(1, 1'b1, 2'd1, 8'd9, 32'd2, 32'h0, "R10 add beats we");
        chk(k_rdata[1] == 32'hFFFF_FFFF, "R7 wrap old", k_rdata[1], 32'hFFFF_FFFF);
        model[9] = 32'd1;
        do_read(0, 8'd9, "R7 wrap stored");

        // R8: compare-and-swap, match and mismatch
        for (int i = 0; i < 4; i++) begin
            logic [7:0] a;
            logic hit;
            a = 8'(40 + i * 3);
            hit = (i % 2 == 0);
            old = model[a];
            issue(i, 1'b0, 2'd2, a, 32'hCAFE_0000 + 32'(i), hit ? old : ~old, "R8 cas grant");
            chk(k_rvalid == (4'b1 << i), "R8 cas return", 32'(k_rvalid), 32'(4'b1 << i));
            chk(k_rdata[i] == old, "R8 cas old value", k_rdata[i], old);
            if (hit) model[a] = 32'hCAFE_0000 + 32'(i);
            do_read((i + 1) % 4, a, "R8 cas stored");
        end

        // R9: lock on bank 2, bank 3 unaffected
        @(negedge clk);
        idle();
        old = model[2];
        k_req[0] = 1'b1; k_op[0] = 2'd1; k_addr[0] = 8'd2; k_wdata[0] = 32'd100;
        #1;
        chk(k_ready == 4'b0001, "R9 atomic grant", 32'(k_ready), 1);
        @(negedge clk);
        idle();
        model[2] = old + 32'd100;
        chk(k_rvalid == 4'b0001, "R9 atomic return", 32'(k_rvalid), 1);
        chk(k_rdata[0] == old, "R9 atomic old", k_rdata[0], old);
        k_req[1] = 1'b1; k_addr[1] = 8'd2;
        k_req[2] = 1'b1; k_addr[2] = 8'd3;
        #1;
        chk(k_ready == 4'b0100, "R9 locked bank waits", 32'(k_ready), 32'b0100);
        @(negedge clk);
        k_req[2] = 1'b0;
        chk(k_rvalid == 4'b0100, "R9 other bank return", 32'(k_rvalid), 32'b0100);
        chk(k_rdata[2] == model[3], "R9 other bank data", k_rdata[2], model[3]);
        #1;
        chk(k_ready == 4'b0010, "R9 grant after lock", 32'(k_ready), 32'b0010);
        @(negedge clk);
        idle();
        chk(k_rvalid == 4'b0010, "R9 late return", 32'(k_rvalid), 32'b0010);
        chk(k_rdata[1] == model[2], "R9 sees atomic result", k_rdata[1], model[2]);

        // R10: op 3 acts as plain write and plain read
        model[20] = 32'h1357_9BDF;
        issue(3, 1'b1, 2'd3, 8'd20, model[20], 32'h0, "R10 op3 write");
        chk(k_rvalid == 4'b0, "R10 op3 write no return", 32'(k_rvalid), 0);
        issue(0, 1'b0, 2'd3, 8'd20, 32'h0, 32'h0, "R10 op3 read");
        chk(k_rvalid == 4'b0001, "R10 op3 read return", 32'(k_rvalid), 1);
        chk(k_rdata[0] == model[20], "R10 op3 read data", k_rdata[0], model[20]);
        do_read(2, 8'd20, "R10 op3 stored");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule